// File: doc/BRIEF.md
# Two-Detector Coincidence Event Qualifier

This block decides whether the trigger lines of a two-detector gamma imaging system form one clean event. One trigger line comes from the absorber (gamma) detector and nineteen come from the pixels of the scatter detector. A rising edge on the gamma line opens a drift window. If exactly one scatter pixel produces a rising edge inside that window, the event becomes a candidate. The block then watches a quiet window, and any trigger edge in it spoils the candidate.

When a candidate completes its quiet window cleanly, the block issues a one-cycle accept pulse. The pulse carries the binary index of the firing pixel and the time stamp that was captured when the gamma edge arrived. A spoiled candidate produces a one-cycle purge pulse instead, so that downstream logic can discard the data it collected. Both window lengths are run-time cycle counts. Typical values are 10 drift cycles and 64 quiet cycles at about 66 MHz.

Top module: `coinc_qualifier`

## Requirements
- R1: While reset is high and in the first cycle after it, accept and purge are low. The stamp counter reads 0 in the first cycle after reset is released.
- R2: While idle, scatter trigger edges start nothing and never produce an accept or purge pulse.
- R3: A gamma rising edge opens a drift window of `drift_cycles` clock cycles, starting with the next cycle. Both lengths are captured at the gamma edge, and a length of 0 acts as 1. Scatter edges in the same cycle as the gamma edge are not counted.
- R4: Exactly one scatter rising edge inside the drift window makes a candidate. Zero edges, or two or more edges (including two lines rising in one cycle), return the block to idle with no pulse. An edge one cycle after the window also goes uncounted.
- R5: A candidate is followed by a quiet window of `integ_cycles` cycles. A rising edge on any trigger line inside it yields a purge pulse, and otherwise an accept pulse results. The pulse is high exactly `drift_cycles + integ_cycles` cycles after the cycle in which the gamma edge was sampled.
- R6: Accept and purge are never high together, and each lasts a single cycle.
- R7: `evt_pixel` is valid with accept and holds the binary bit position (0 to N_SCAT-1) of the single scatter line that fired.
- R8: `evt_stamp` is valid with accept. It holds the free-running stamp counter value from the cycle in which the gamma edge was presented. The counter increments by one per clock and wraps at 2^STAMP_W.
- R9: The block is idle again in the cycle of the accept or purge pulse, so a gamma edge in that cycle starts a new event.
- R10: Only rising edges count. A scatter line that rises in the drift window and stays high through the quiet window does not spoil the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gamma_trig | input | 1 | Absorber detector trigger level |
| scat_trig | input | N_SCAT | Scatter pixel trigger levels, one bit per pixel |
| drift_cycles | input | WIN_W | Drift window length in cycles (0 treated as 1) |
| integ_cycles | input | WIN_W | Quiet window length in cycles (0 treated as 1) |
| evt_accept | output | 1 | One-cycle accept pulse |
| evt_purge | output | 1 | One-cycle purge pulse |
| evt_pixel | output | $clog2(N_SCAT) | Index of the firing scatter pixel |
| evt_stamp | output | STAMP_W | Time stamp of the gamma edge |

## Verification
The bench builds the block with the full 19 scatter lines, so the top pixel index 18 and the 5-bit pixel encoding are exercised. STAMP_W is narrowed to 8, so the stamp counter wraps after 256 cycles and the bench can reach a wrapped stamp in a short run. Window lengths come from ports. The bench drives short windows, windows of zero length, and edges placed on the last drift cycle and on the first cycle after it. This keeps every window boundary and the back-to-back restart within a few cycles of each other.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIFT = 2'd1,
        PH_QUIET = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_ONE  = 2'd1,
        HIT_MANY = 2'd2
    } hit_lvl_t;

    // Saturating merge of the running hit level with this cycle's (pre-saturated) count.
    function automatic hit_lvl_t hit_merge(input hit_lvl_t cur, input logic [1:0] add);
        int s;
        s = int'(cur) + int'(add);
        if (s >= 2)
            return HIT_MANY;
        else if (s == 1)
            return HIT_ONE;
        return HIT_NONE;
    endfunction

endpackage

// File: rtl/coinc_edge_detect.sv
module coinc_edge_detect #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                prev_q[b] <= 1'b0;
            else
                prev_q[b] <= lvl[b];
        end
        assign rise[b] = lvl[b] & ~prev_q[b];
    end
endmodule

// File: rtl/coinc_stamp_counter.sv
module coinc_stamp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] stamp
);
    always_ff @(posedge clk) begin
        if (rst)
            stamp <= '0;
        else
            stamp <= stamp + W'(1);
    end
endmodule

// File: rtl/coinc_hit_tracker.sv
module coinc_hit_tracker
    import coinc_pkg::*;
#(
    parameter int N     = 19,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic [N-1:0]     rise,
    output hit_lvl_t         lvl_now,
    output logic [IDX_W-1:0] idx_now
);
    hit_lvl_t         lvl_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] enc;
    logic [1:0]       add_sat;
    int               n_hits;

    always_comb begin
        n_hits = 0;
        enc    = '0;
        for (int b = N - 1; b >= 0; b--) begin
            if (rise[b]) begin
                n_hits = n_hits + 1;
                enc    = IDX_W'(b);
            end
        end
        add_sat = (n_hits >= 2) ? 2'd2 : 2'(n_hits);
        lvl_now = hit_merge(lvl_q, add_sat);
        idx_now = (lvl_q == HIT_NONE && add_sat == 2'd1) ? enc : idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lvl_q <= HIT_NONE;
            idx_q <= '0;
        end else if (enable) begin
            lvl_q <= lvl_now;
            idx_q <= idx_now;
        end
    end
endmodule

// File: rtl/coinc_sequencer.sv
module coinc_sequencer
    import coinc_pkg::*;
#(
    parameter int WIN_W   = 8,
    parameter int STAMP_W = 16,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               g_rise,
    input  logic               s_rise_any,
    input  logic [WIN_W-1:0]   drift_cycles,
    input  logic [WIN_W-1:0]   integ_cycles,
    input  logic [STAMP_W-1:0] stamp,
    input  hit_lvl_t           hit_lvl_now,
    input  logic [IDX_W-1:0]   hit_idx_now,
    output logic               trk_clear,
    output logic               trk_en,
    output logic               accept,
    output logic               purge,
    output logic [IDX_W-1:0]   pixel,
    output logic [STAMP_W-1:0] stamp_out
);
    phase_t             phase_q;
    logic [WIN_W-1:0]   cnt_q;
    logic [WIN_W-1:0]   drift_len_q;
    logic [WIN_W-1:0]   integ_len_q;
    logic [STAMP_W-1:0] stamp_q;
    logic [IDX_W-1:0]   pix_q;
    logic               spoiled_q;
    logic               spoil_now;
    logic               drift_last;
    logic               quiet_last;

    assign trk_clear  = (phase_q == PH_IDLE);
    assign trk_en     = (phase_q == PH_DRIFT);
    assign spoil_now  = spoiled_q | g_rise | s_rise_any;
    assign drift_last = (cnt_q == drift_len_q - WIN_W'(1));
    assign quiet_last = (cnt_q == integ_len_q - WIN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            drift_len_q <= WIN_W'(1);
            integ_len_q <= WIN_W'(1);
            stamp_q     <= '0;
            pix_q       <= '0;
            spoiled_q   <= 1'b0;
            accept      <= 1'b0;
            purge       <= 1'b0;
            pixel       <= '0;
            stamp_out   <= '0;
        end else begin
            accept <= 1'b0;
            purge  <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (g_rise) begin
                        phase_q     <= PH_DRIFT;
                        cnt_q       <= '0;
                        drift_len_q <= (drift_cycles == '0) ? WIN_W'(1) : drift_cycles;
                        integ_len_q <= (integ_cycles == '0) ? WIN_W'(1) : integ_cycles;
                        stamp_q     <= stamp;
                    end
                end
                PH_DRIFT: begin
                    cnt_q <= cnt_q + WIN_W'(1);
                    if (drift_last) begin
                        cnt_q     <= '0;
                        spoiled_q <= 1'b0;
                        pix_q     <= hit_idx_now;
                        phase_q   <= (hit_lvl_now == HIT_ONE) ? PH_QUIET : PH_IDLE;
                    end
                end
                PH_QUIET: begin
                    cnt_q     <= cnt_q + WIN_W'(1);
                    spoiled_q <= spoil_now;
                    if (quiet_last) begin
                        phase_q   <= PH_IDLE;
                        cnt_q     <= '0;
                        accept    <= ~spoil_now;
                        purge     <= spoil_now;
                        pixel     <= pix_q;
                        stamp_out <= stamp_q;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/coinc_qualifier.sv
module coinc_qualifier
    import coinc_pkg::*;
#(
    parameter int  N_SCAT  = 19,
    parameter int  STAMP_W = 16,
    parameter int  WIN_W   = 8,
    localparam int IDX_W   = (N_SCAT > 1) ? $clog2(N_SCAT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gamma_trig,
    input  logic [N_SCAT-1:0]  scat_trig,
    input  logic [WIN_W-1:0]   drift_cycles,
    input  logic [WIN_W-1:0]   integ_cycles,
    output logic               evt_accept,
    output logic               evt_purge,
    output logic [IDX_W-1:0]   evt_pixel,
    output logic [STAMP_W-1:0] evt_stamp
);
    logic               g_rise;
    logic [N_SCAT-1:0]  s_rise;
    logic [STAMP_W-1:0] stamp;
    logic               trk_clear;
    logic               trk_en;
    hit_lvl_t           hit_lvl_now;
    logic [IDX_W-1:0]   hit_idx_now;

    coinc_edge_detect #(.W(1)) u_gamma_edge (
        .clk(clk), .rst(rst), .lvl(gamma_trig), .rise(g_rise)
    );

    coinc_edge_detect #(.W(N_SCAT)) u_scat_edge (
        .clk(clk), .rst(rst), .lvl(scat_trig), .rise(s_rise)
    );

    coinc_stamp_counter #(.W(STAMP_W)) u_stamp (
        .clk(clk), .rst(rst), .stamp(stamp)
    );

    coinc_hit_tracker #(.N(N_SCAT), .IDX_W(IDX_W)) u_tracker (
        .clk(clk), .rst(rst), .clear(trk_clear), .enable(trk_en),
        .rise(s_rise), .lvl_now(hit_lvl_now), .idx_now(hit_idx_now)
    );

    coinc_sequencer #(.WIN_W(WIN_W), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .g_rise(g_rise), .s_rise_any(|s_rise),
        .drift_cycles(drift_cycles), .integ_cycles(integ_cycles),
        .stamp(stamp), .hit_lvl_now(hit_lvl_now), .hit_idx_now(hit_idx_now),
        .trk_clear(trk_clear), .trk_en(trk_en),
        .accept(evt_accept), .purge(evt_purge),
        .pixel(evt_pixel), .stamp_out(evt_stamp)
    );
endmodule

// File: rtl/coinc_qualifier_chk.sv
module coinc_qualifier_chk #(
    parameter int  N_SCAT = 19,
    localparam int IDX_W  = (N_SCAT > 1) ? $clog2(N_SCAT) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_accept,
    input logic             evt_purge,
    input logic [IDX_W-1:0] evt_pixel
);
    // R1: no pulse in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!evt_accept && !evt_purge));

    // R6: accept and purge exclusive
    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(evt_accept && evt_purge));

    // R6: accept is a single-cycle pulse
    p_accept_single_r6: assert property (@(posedge clk) disable iff (rst)
        evt_accept |=> !evt_accept);

    // R6: purge is a single-cycle pulse
    p_purge_single_r6: assert property (@(posedge clk) disable iff (rst)
        evt_purge |=> !evt_purge);

    // R7: reported pixel index lies within the scatter array
    p_pixel_range_r7: assert property (@(posedge clk) disable iff (rst)
        evt_accept |-> (int'(evt_pixel) < N_SCAT));
endmodule

bind coinc_qualifier coinc_qualifier_chk #(.N_SCAT(N_SCAT)) u_chk (
    .clk(clk), .rst(rst), .evt_accept(evt_accept),
    .evt_purge(evt_purge), .evt_pixel(evt_pixel)
);

// File: tb/coinc_qualifier_test.sv
module coinc_qualifier_test;
    localparam int N  = 19;
    localparam int SW = 8;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          g   = 1'b0;
    logic [N-1:0]  sc  = '0;
    logic [WW-1:0] dlen = '0;
    logic [WW-1:0] ilen = '0;
    logic          acc;
    logic          pur;
    logic [4:0]    pix;
    logic [SW-1:0] stp;

    int nchk = 0;
    int nerr = 0;
    int nacc = 0;
    int npur = 0;
    int bc   = 0;
    int exp_ts = 0;

    always #2.5 clk = ~clk;

    coinc_qualifier #(.N_SCAT(N), .STAMP_W(SW), .WIN_W(WW)) uut (
        .clk(clk), .rst(rst), .gamma_trig(g), .scat_trig(sc),
        .drift_cycles(dlen), .integ_cycles(ilen),
        .evt_accept(acc), .evt_purge(pur), .evt_pixel(pix), .evt_stamp(stp)
    );

    always @(posedge clk) begin
        if (rst) bc <= 0;
        else     bc <= bc + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (acc) nacc++;
            if (pur) npur++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic pulse_sc(input logic [N-1:0] m);
        sc = m;
        tick();
        sc = '0;
    endtask

    task automatic start_gamma(input int d, input int i);
        dlen = WW'(d);
        ilen = WW'(i);
        g = 1'b1;
        exp_ts = bc % 256;
        tick();
        g = 1'b0;
    endtask

    task automatic expect_accept(input int p, input string req);
        chk(acc === 1'b1, {req, " accept"}, int'(acc), 1);
        chk(pur === 1'b0, "R6 purge low with accept", int'(pur), 0);
        chk(int'(pix) == p, "R7 pixel", int'(pix), p);
        chk(int'(stp) == exp_ts, "R8 stamp", int'(stp), exp_ts);
    endtask

    task automatic t_reset();
        chk(acc === 1'b0, "R1 accept after reset", int'(acc), 0);
        chk(pur === 1'b0, "R1 purge after reset", int'(pur), 0);
    endtask

    task automatic t_idle_ignore();
        int a0 = nacc, p0 = npur;
        pulse_sc(19'h00001);
        idle(2);
        pulse_sc(19'h40010);
        idle(20);
        chk(nacc == a0 && npur == p0, "R2 idle scatter ignored", nacc + npur, a0 + p0);
    endtask

    task automatic t_accept_basic();
        start_gamma(4, 6);
        idle(2);
        pulse_sc(19'h40000);
        idle(1);
        idle(5);
        chk(acc === 1'b0 && pur === 1'b0, "R5 no pulse one cycle early", int'(acc | pur), 0);
        tick();
        expect_accept(18, "R5");
        tick();
        chk(acc === 1'b0, "R6 accept single cycle", int'(acc), 0);
    endtask

    task automatic t_zero_hits();
        int a0 = nacc, p0 = npur;
        start_gamma(3, 5);
        idle(10);
        chk(nacc == a0 && npur == p0, "R4 zero hits no pulse", nacc + npur, a0 + p0);
    endtask

    task automatic t_two_hits();
        int a0 = nacc, p0 = npur;
        start_gamma(5, 4);
        pulse_sc(19'h00002);
        idle(2);
        pulse_sc(19'h00080);
        idle(7);
        chk(nacc == a0 && npur == p0, "R4 two hits no pulse", nacc + npur, a0 + p0);
    endtask

    task automatic t_same_cycle();
        int a0 = nacc, p0 = npur;
        start_gamma(4, 4);
        idle(1);
        pulse_sc(19'h00600);
        idle(8);
        chk(nacc == a0 && npur == p0, "R4 same-cycle pair no pulse", nacc + npur, a0 + p0);
    endtask

    task automatic t_spoil(input bit by_gamma);
        start_gamma(3, 6);
        pulse_sc(19'h00010);
        idle(2);
        idle(2);
        if (by_gamma) begin
            g = 1'b1; tick(); g = 1'b0;
        end else begin
            pulse_sc(19'h00800);
        end
        idle(3);
        chk(pur === 1'b1, by_gamma ? "R5 purge by gamma" : "R5 purge by scatter", int'(pur), 1);
        chk(acc === 1'b0, "R6 accept low with purge", int'(acc), 0);
        tick();
        chk(pur === 1'b0, "R6 purge single cycle", int'(pur), 0);
    endtask

    task automatic t_own_cycle();
        dlen = 8'd4;
        ilen = 8'd5;
        g = 1'b1;
        sc = 19'h00020;
        exp_ts = bc % 256;
        tick();
        g = 1'b0;
        sc = '0;
        idle(1);
        pulse_sc(19'h00008);
        idle(2);
        idle(5);
        expect_accept(3, "R3 gamma-cycle edge not counted");
    endtask

    task automatic t_boundaries();
        int a0, p0;
        start_gamma(4, 5);
        idle(3);
        pulse_sc(19'h00001);
        idle(5);
        expect_accept(0, "R3 last drift cycle");
        idle(2);
        a0 = nacc; p0 = npur;
        start_gamma(4, 5);
        idle(4);
        pulse_sc(19'h00001);
        idle(8);
        chk(nacc == a0 && npur == p0, "R4 edge after window ignored", nacc + npur, a0 + p0);
    endtask

    task automatic t_zero_len();
        start_gamma(0, 5);
        pulse_sc(19'h01000);
        idle(5);
        expect_accept(12, "R3 zero drift acts as one");
        idle(2);
        start_gamma(0, 0);
        pulse_sc(19'h00004);
        idle(1);
        expect_accept(2, "R3 zero lengths act as one");
        idle(2);
    endtask

    task automatic t_back_to_back();
        start_gamma(2, 3);
        pulse_sc(19'h00040);
        idle(1);
        idle(3);
        expect_accept(6, "R9 first event");
        start_gamma(2, 3);
        pulse_sc(19'h00080);
        idle(1);
        idle(3);
        expect_accept(7, "R9 restart in pulse cycle");
        idle(2);
    endtask

    task automatic t_held();
        start_gamma(4, 5);
        idle(1);
        sc = 19'h00004;
        tick();
        idle(2);
        idle(5);
        expect_accept(2, "R10 held level no spoil");
        sc = '0;
        idle(2);
    endtask

    task automatic t_wrap();
        idle(300);
        start_gamma(3, 3);
        pulse_sc(19'h20000);
        idle(2);
        idle(3);
        expect_accept(17, "R8 wrapped stamp");
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk(acc === 1'b0 && pur === 1'b0, "R1 outputs low in reset", int'(acc | pur), 0);
        idle(3);
        rst = 1'b0;
        tick();
        t_reset();
        chk(int'(stp) == 0, "R1 stamp output cleared", int'(stp), 0);
        t_idle_ignore();
        t_accept_basic();
        t_zero_hits();
        t_two_hits();
        t_same_cycle();
        t_spoil(1'b0);
        t_spoil(1'b1);
        t_own_cycle();
        t_boundaries();
        t_zero_len();
        t_back_to_back();
        t_held();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule